// File: doc/BRIEF.md
# Programmable Serial Bit Clock Divider

This block derives a serial bit clock from one of two tick sources and divides it by a programmable amount. The internal source produces one tick every fourth system clock. The external source treats each system cycle in which the external reference input is high as one tick. An 8-bit divide value D sets the output period to D + 1 ticks. The phase split follows the divide value. Even values make the high phase one tick longer than the low phase. Odd values split the period evenly.

Besides the divided clock level, the block raises a one-cycle strobe in the first system cycle of each high phase and another in the first system cycle of each low phase. A serial shifter uses these strobes to launch and capture data without detecting edges itself. A new divide value is picked up only when the next high phase starts, so a reprogramming never produces a short pulse. When the enable is low, the output rests low and both strobes are silent. The first tick after enabling starts a high phase.

Top module: `bclk_divider`

## Requirements
- R1: The output period is D + 1 ticks for every divide value D greater than zero.
- R2: For an even D greater than zero, the high phase lasts D/2 + 1 ticks and the low phase lasts D/2 ticks. For example, D = 2 gives 2 high and 1 low, and D = 254 gives 128 high and 127 low.
- R3: For an odd D, the high and low phases each last (D + 1)/2 ticks. For example, D = 255 gives 128 and 128.
- R4: With D = 0, each tick drives the clock high for exactly one system cycle, provided ticks are at least two system cycles apart.
- R5: With src_ext = 0, a tick occurs every 4 system cycles. The first tick is sampled on the 4th rising system clock edge after en is first seen high. D = 1 therefore gives an 8-cycle period, 4 cycles high and 4 low.
- R6: With src_ext = 1, every system cycle in which ext_ref is high is one tick, and cycles with ext_ref low are not ticks. Ticks may be irregular.
- R7: bclk_rise is high only in the first system cycle of a high phase, and bclk_fall only in the first cycle of a low phase. The two are never high together.
- R8: A divide value change takes effect only at the next start of a high phase. The phase in progress keeps its length.
- R9: While en is low, bclk is low and neither strobe fires. Dropping en during a high phase brings bclk low without a fall strobe. After re-enabling, the first tick starts a high phase.
- R10: A synchronous active-high reset clears bclk, bclk_rise and bclk_fall to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Divider enable |
| src_ext | input | 1 | Tick source: 0 = internal quarter-rate, 1 = external reference |
| ext_ref | input | 1 | External reference, one tick per cycle high |
| div_val | input | 8 | Divide value D |
| bclk | output | 1 | Divided bit clock level |
| bclk_rise | output | 1 | One-cycle strobe at the start of each high phase |
| bclk_fall | output | 1 | One-cycle strobe at the start of each low phase |

## Verification
The internal source is run with D = 1, 0, 3 and 6. These runs separate the quarter-rate tick spacing from the divide arithmetic and compare the odd split against the even split. The external source is first driven with a tick in every cycle at D = 2, 254 and 255, which exposes off-by-one errors in phase lengths at the small and large ends of the range. It is then driven with an irregular tick pattern, which shows that the divider counts ticks rather than system cycles. The divide value is also changed in the middle of a high phase to show that the change waits for the next rising edge, and the enable is dropped in the middle of a high phase to confirm that the output goes quiet with no stray strobe.

// File: rtl/bclk_div_pkg.sv
package bclk_div_pkg;

    // Widest divide value the phase-length helpers support.
    localparam int DIV_CAP_W = 16;

    // Divider phase state.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // Registered clock outputs carried as one bundle.
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } bclk_out_t;

    // Ticks spent high: d/2 + 1 for even d, (d+1)/2 for odd d. Both reduce to floor(d/2)+1.
    function automatic logic [DIV_CAP_W-1:0] high_ticks(input logic [DIV_CAP_W-1:0] d);
        return (d >> 1) + DIV_CAP_W'(1);
    endfunction

    // Ticks spent low: whatever remains of the d+1 tick period.
    function automatic logic [DIV_CAP_W-1:0] low_ticks(input logic [DIV_CAP_W-1:0] d);
        return (d >> 1) + DIV_CAP_W'(d[0]);
    endfunction

endpackage

// File: rtl/bclk_tick_src.sv
module bclk_tick_src #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic src_ext,
    input  logic ext_ref,
    output logic tick
);

    logic int_tick;

    generate
        if (PRESCALE <= 1) begin : g_direct
            // Every enabled system cycle is a tick.
            assign int_tick = en & ~rst;
        end else begin : g_count
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

            logic [PW-1:0] pre_cnt;

            always_ff @(posedge clk) begin
                if (rst || !en) begin
                    pre_cnt <= '0;
                end else if (pre_cnt == PRE_LAST) begin
                    pre_cnt <= '0;
                end else begin
                    pre_cnt <= pre_cnt + PW'(1);
                end
            end

            assign int_tick = en && (pre_cnt == PRE_LAST);

            // Internal ticks are never back to back.
            assert_tick_gap_R5: assert property (@(posedge clk) disable iff (rst)
                int_tick |=> !int_tick);
        end
    endgenerate

    assign tick = src_ext ? (en && ext_ref) : int_tick;

endmodule

// File: rtl/bclk_phase_core.sv
module bclk_phase_core
    import bclk_div_pkg::*;
#(
    parameter int DIV_W = 8   // must not exceed DIV_CAP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_in,
    output bclk_out_t        out_q
);

    localparam int CW = DIV_CAP_W;

    phase_e           state;
    logic [DIV_W-1:0] cur_div;   // divide value owned by the current period
    logic [DIV_W-1:0] cnt;       // ticks already spent in the current phase
    logic [CW-1:0]    cnt_next;
    logic [CW-1:0]    hi_len;
    logic [CW-1:0]    lo_len;
    logic             zero_div;

    always_comb begin
        cnt_next = CW'(cnt) + CW'(1);
        hi_len   = high_ticks(CW'(cur_div));
        lo_len   = low_ticks(CW'(cur_div));
        zero_div = (cur_div == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state   <= PH_IDLE;
            out_q   <= '0;
            cnt     <= '0;
            cur_div <= '0;
        end else begin
            out_q.rise <= 1'b0;
            out_q.fall <= 1'b0;
            unique case (state)
                PH_IDLE: begin
                    if (tick) begin
                        state      <= PH_HIGH;
                        out_q.lvl  <= 1'b1;
                        out_q.rise <= 1'b1;
                        cur_div    <= div_in;
                        cnt        <= '0;
                    end
                end
                PH_HIGH: begin
                    if (zero_div) begin
                        // Pass-through: one system cycle high, then wait for the next tick.
                        state      <= PH_IDLE;
                        out_q.lvl  <= 1'b0;
                        out_q.fall <= 1'b1;
                    end else if (tick) begin
                        if (cnt_next == hi_len) begin
                            state      <= PH_LOW;
                            out_q.lvl  <= 1'b0;
                            out_q.fall <= 1'b1;
                            cnt        <= '0;
                        end else begin
                            cnt <= cnt + DIV_W'(1);
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (cnt_next == lo_len) begin
                            state      <= PH_HIGH;
                            out_q.lvl  <= 1'b1;
                            out_q.rise <= 1'b1;
                            cur_div    <= div_in;
                            cnt        <= '0;
                        end else begin
                            cnt <= cnt + DIV_W'(1);
                        end
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    // R7: strobes exclusive and aligned to level changes
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(out_q.rise && out_q.fall));
    assert_rise_level_R7: assert property (@(posedge clk) disable iff (rst)
        out_q.rise |-> (out_q.lvl && !$past(out_q.lvl)));
    assert_fall_level_R7: assert property (@(posedge clk) disable iff (rst)
        out_q.fall |-> (!out_q.lvl && $past(out_q.lvl)));
    // R9: disabled means quiet
    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!out_q.lvl && !out_q.rise && !out_q.fall));
    // R8: period divide value frozen through a high phase
    assert_div_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_q.lvl && !out_q.rise) |-> $stable(cur_div));

endmodule

// File: rtl/bclk_divider.sv
module bclk_divider
    import bclk_div_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             src_ext,
    input  logic             ext_ref,
    input  logic [DIV_W-1:0] div_val,
    output logic             bclk,
    output logic             bclk_rise,
    output logic             bclk_fall
);

    logic      tick;
    bclk_out_t core_out;

    bclk_tick_src #(
        .PRESCALE (PRESCALE)
    ) u_tick_src (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .src_ext (src_ext),
        .ext_ref (ext_ref),
        .tick    (tick)
    );

    bclk_phase_core #(
        .DIV_W (DIV_W)
    ) u_phase_core (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .tick   (tick),
        .div_in (div_val),
        .out_q  (core_out)
    );

    assign bclk      = core_out.lvl;
    assign bclk_rise = core_out.rise;
    assign bclk_fall = core_out.fall;

endmodule

// File: tb/bclk_divider_bench.sv
module bclk_divider_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    edge_no;
        bit    is_rise;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       src_ext = 1'b0;
    logic       ext_ref = 1'b0;
    logic [7:0] div_val = 8'd0;
    logic       bclk;
    logic       bclk_rise;
    logic       bclk_fall;

    int    cyc = 0;
    int    vectors = 0;
    int    fails = 0;
    string cur_tag = "R10";
    exp_t  exp_q[$];

    // Requirement-level model state
    int m_state = 0;   // 0 waiting, 1 high, 2 low
    int m_cnt   = 0;
    int m_cur   = 0;
    int m_pre   = 0;
    bit m_lvl   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always_ff @(posedge clk) cyc <= cyc + 1;

    bclk_divider u_bclk_divider (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .src_ext   (src_ext),
        .ext_ref   (ext_ref),
        .div_val   (div_val),
        .bclk      (bclk),
        .bclk_rise (bclk_rise),
        .bclk_fall (bclk_fall)
    );

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic push_evt(input int e, input bit r, input string tag);
        exp_t it;
        it.edge_no = e;
        it.is_rise = r;
        it.tag     = tag;
        exp_q.push_back(it);
    endtask

    // Driver: one call per system cycle, called at a falling edge.
    task automatic step(input bit e, input bit s, input bit x, input int d, input string tag);
        bit tk;
        int hi;
        int lo;
        int nxt;
        check(bclk === m_lvl, tag, "bclk level", int'(bclk), int'(m_lvl));
        cur_tag = tag;
        en      = e;
        src_ext = s;
        ext_ref = x;
        div_val = 8'(d);
        tk    = e && (s ? x : (m_pre == 3));
        m_pre = e ? (m_pre + 1) % 4 : 0;
        nxt   = cyc + 1;
        hi    = m_cur / 2 + 1;
        lo    = m_cur + 1 - hi;
        if (!e) begin
            m_state = 0; m_lvl = 1'b0; m_cnt = 0;
        end else if (m_state == 0) begin
            if (tk) begin
                push_evt(nxt, 1'b1, tag);
                m_state = 1; m_lvl = 1'b1; m_cur = d; m_cnt = 0;
            end
        end else if (m_state == 1) begin
            if (m_cur == 0) begin
                push_evt(nxt, 1'b0, tag);
                m_state = 0; m_lvl = 1'b0;
            end else if (tk) begin
                if (m_cnt + 1 == hi) begin
                    push_evt(nxt, 1'b0, tag);
                    m_state = 2; m_lvl = 1'b0; m_cnt = 0;
                end else m_cnt++;
            end
        end else begin
            if (tk) begin
                if (m_cnt + 1 == lo) begin
                    push_evt(nxt, 1'b1, tag);
                    m_state = 1; m_lvl = 1'b1; m_cur = d; m_cnt = 0;
                end else m_cnt++;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 0, "R9");
    endtask

    // Monitor: pops expected strobes as the design produces them.
    always @(negedge clk) begin
        if (!rst) begin
            if (bclk_rise === 1'b1 && bclk_fall === 1'b1)
                check(1'b0, "R7", "both strobes high", 1, 0);
            if (bclk_rise === 1'b1 || bclk_fall === 1'b1) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected strobe, rise", int'(bclk_rise), 0);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    check(it.edge_no == cyc, it.tag, "strobe cycle", cyc, it.edge_no);
                    check(bclk_rise === it.is_rise, it.tag, "strobe kind (1=rise)",
                          int'(bclk_rise), int'(it.is_rise));
                end
            end else if (exp_q.size() != 0 && exp_q[0].edge_no <= cyc) begin
                exp_t it;
                it = exp_q.pop_front();
                check(1'b0, it.tag, "missing strobe at cycle", cyc, it.edge_no);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired: actual %0d cycles expected fewer", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check(bclk === 1'b0, "R10", "bclk after reset", int'(bclk), 0);
        check(bclk_rise === 1'b0, "R10", "rise after reset", int'(bclk_rise), 0);
        check(bclk_fall === 1'b0, "R10", "fall after reset", int'(bclk_fall), 0);
        idle(3);

        // R5: internal quarter-rate, D=1 (8-cycle period, 4/4)
        for (int i = 0; i < 48; i++) step(1'b1, 1'b0, 1'b0, 1, "R5");
        idle(3);
        // R4: internal, D=0 pass-through
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, 0, "R4");
        idle(3);
        // R3: internal, odd D=3
        for (int i = 0; i < 70; i++) step(1'b1, 1'b0, 1'b0, 3, "R3");
        idle(3);
        // R1: internal, D=6 period of 7 ticks
        for (int i = 0; i < 90; i++) step(1'b1, 1'b0, 1'b0, 6, "R1");
        idle(3);
        // R2: external every cycle, D=2
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b1, 2, "R2");
        idle(3);
        // R2: large even D=254
        for (int i = 0; i < 600; i++) step(1'b1, 1'b1, 1'b1, 254, "R2");
        idle(3);
        // R3: largest odd D=255
        for (int i = 0; i < 600; i++) step(1'b1, 1'b1, 1'b1, 255, "R3");
        idle(3);
        // R6: irregular external ticks, D=5
        for (int i = 0; i < 150; i++)
            step(1'b1, 1'b1, bit'((i % 3 == 0) || (i % 7 == 2)), 5, "R6");
        idle(3);
        // R8: D=4 then switch to D=1 during the first high phase
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 4, "R8");
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b1, 1, "R8");
        idle(3);
        // R9: disable in mid high phase, then re-enable
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 8, "R9");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, 8, "R9");
        for (int i = 0; i < 25; i++) step(1'b1, 1'b1, 1'b1, 3, "R9");
        idle(4);

        check(exp_q.size() == 0, "R7", "pending expected strobes", exp_q.size(), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule